// File: doc/BRIEF.md
# Shared-bus flash and pseudo-SRAM controller

This controller sits on the host side of a board bus that one burst flash die and one pseudo-SRAM die share. It takes one request at a time through a valid/ready handshake. A request carries a write flag, a target select, a word address, write data and byte enables. The controller turns each request into a fixed asynchronous single-word cycle on the shared bus and drives the control strobes for the selected die. Read data comes back with a one-cycle response pulse.

Every access runs the same phases. A setup cycle opens the flash address latch or presents the byte enables. A strobe phase of `STROBE_CYC` clocks follows, with the default covering a 70 ns access at a 10 ns clock. Then come one hold cycle and one turnaround cycle in which neither die is selected. Only the flash sees the top address bits, so the controller forces them to zero during pseudo-SRAM cycles. The flash reset output is held low while the controller is in reset. Each flash cycle begins by opening the address latch, which gives the falling edge the flash needs before its read data counts as valid after a reset.

Top module: `shared_mem_ctrl`

## Requirements
- R1: While reset is applied and when idle after reset, every active-low control output is high, `ps_ce2` is high, `mem_dq_oe` is low and `req_ready` is high. `fl_rst_n` is low during reset and high from the first clock after release.
- R2: `fl_ce_n` and `ps_ce1_n` are never low together. After either one rises, both stay high for at least one more full cycle.
- R3: `mem_addr` bits 20:0 equal the request address during an access. Bits 22:21 follow the request for a flash access (`req_sel`=0) and are 0 for a pseudo-SRAM access (`req_sel`=1).
- R4: In the setup cycle of a flash access, `fl_addr_lat_n` is low while `fl_ce_n` falls. It rises when the strobe phase starts and stays high while `fl_oe_n` or `fl_we_n` is low. The flash captures the address on that rising edge.
- R5: Each access has exactly one setup cycle with the target chip enable low and its strobe high. Then the strobe (output enable for a read, write enable for a write) is low for exactly `STROBE_CYC` cycles. Then comes one hold cycle with the chip enable still low and the strobe high.
- R6: During a write, `mem_dq_oe` is high and `mem_dq_out` holds the write data from setup through the hold cycle, so the data stays driven after the write enable rises. `mem_dq_oe` is low during reads, idle and turnaround.
- R7: During a pseudo-SRAM access, `ps_lb_n` = NOT `req_be[0]` (gating bits 7:0) and `ps_ub_n` = NOT `req_be[1]` (gating bits 15:8). Both are high during flash accesses and when idle.
- R8: A read yields a `rsp_valid` pulse of one cycle, in the hold cycle. `rsp_rdata` is the bus value at the end of the strobe. A pseudo-SRAM read returns disabled bytes as zero, and a flash read returns the whole word. Writes give no response.
- R9: `req_ready` is low from the setup cycle through the turnaround cycle. A request held valid during that time is not taken until the controller returns to idle, so accepts are at least `STROBE_CYC`+4 clocks apart.
- R10: Data written through the controller to either die reads back through the controller with the expected value, including byte-masked pseudo-SRAM writes (disabled bytes keep their old contents).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = flash, 1 = pseudo-SRAM |
| req_addr | input | 23 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 23 | Shared address bus |
| mem_dq_out | output | 16 | Data driven onto the shared bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data read from the shared bus |
| fl_rst_n | output | 1 | Flash reset, active low |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr_lat_n | output | 1 | Flash address latch, low = transparent |
| ps_ce1_n | output | 1 | Pseudo-SRAM chip enable, active low |
| ps_ce2 | output | 1 | Pseudo-SRAM power-down control, held high |
| ps_oe_n | output | 1 | Pseudo-SRAM output enable, active low |
| ps_we_n | output | 1 | Pseudo-SRAM write enable, active low |
| ps_ub_n | output | 1 | Pseudo-SRAM upper byte enable, active low |
| ps_lb_n | output | 1 | Pseudo-SRAM lower byte enable, active low |

## Verification
A new request can arrive in the same cycle that the read response of the previous access leaves, which is the hold cycle, or in the turnaround cycle that follows. The bench provokes this by keeping `req_valid` high with the next request through the whole access, and it often switches die between consecutive requests. It then checks three things: `req_ready` stays low through hold and turnaround, the response pulse still arrives exactly once in the hold cycle, and the new die's chip enable falls no earlier than the cycle after the turnaround.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_t;

  typedef enum logic {
    TGT_FLASH = 1'b0,
    TGT_PSRAM = 1'b1
  } tgt_t;

  // A die is selected in setup, strobe and hold.
  function automatic logic phase_busy(input phase_t p);
    return (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_HOLD);
  endfunction
endpackage

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int AW         = 23,
  parameter int DW         = 16,
  parameter int BEW        = 2,
  parameter int STROBE_CYC = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic           req_sel,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [BEW-1:0] req_be,
  output logic           req_ready,
  output phase_t         phase,
  output tgt_t           tgt,
  output logic           wr,
  output logic [AW-1:0]  addr,
  output logic [DW-1:0]  wdata,
  output logic [BEW-1:0] be,
  output logic           strobe_last
);
  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign req_ready   = (phase == PH_IDLE);
  assign accept      = req_valid && req_ready;
  assign strobe_last = (phase == PH_STROBE) && (cnt == CNT_W'(STROBE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      tgt   <= TGT_FLASH;
      wr    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
      be    <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          phase <= PH_SETUP;
          tgt   <= tgt_t'(req_sel);
          wr    <= req_write;
          addr  <= req_addr;
          wdata <= req_wdata;
          be    <= req_be;
        end
        PH_SETUP: begin
          phase <= PH_STROBE;
          cnt   <= '0;
        end
        PH_STROBE: begin
          if (strobe_last) phase <= PH_HOLD;
          else             cnt   <= cnt + CNT_W'(1);
        end
        PH_HOLD: phase <= PH_TURN;
        PH_TURN: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smc_pins.sv
module smc_pins
  import smc_pkg::*;
#(
  parameter int AW        = 23,
  parameter int DW        = 16,
  parameter int BEW       = 2,
  parameter int SHARED_AW = 21
) (
  input  phase_t         phase,
  input  tgt_t           tgt,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [BEW-1:0] be,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_dq_out,
  output logic           mem_dq_oe,
  output logic           fl_ce_n,
  output logic           fl_oe_n,
  output logic           fl_we_n,
  output logic           fl_addr_lat_n,
  output logic           ps_ce1_n,
  output logic           ps_ce2,
  output logic           ps_oe_n,
  output logic           ps_we_n,
  output logic           ps_ub_n,
  output logic           ps_lb_n
);
  localparam logic [AW-1:0] SHARED_MASK = {{(AW-SHARED_AW){1'b0}}, {SHARED_AW{1'b1}}};

  // Upper bits reach only the flash die; blank them for PSRAM cycles.
  function automatic logic [AW-1:0] gate_addr(input tgt_t t, input logic [AW-1:0] a);
    return (t == TGT_PSRAM) ? (a & SHARED_MASK) : a;
  endfunction

  logic busy, strobe, fl_sel, ps_sel;

  assign busy   = phase_busy(phase);
  assign strobe = (phase == PH_STROBE);
  assign fl_sel = busy && (tgt == TGT_FLASH);
  assign ps_sel = busy && (tgt == TGT_PSRAM);

  assign mem_addr   = busy ? gate_addr(tgt, addr) : '0;
  assign mem_dq_oe  = busy && wr;
  assign mem_dq_out = (busy && wr) ? wdata : '0;

  assign fl_ce_n       = !fl_sel;
  assign fl_oe_n       = !(fl_sel && strobe && !wr);
  assign fl_we_n       = !(fl_sel && strobe && wr);
  assign fl_addr_lat_n = !(fl_sel && (phase == PH_SETUP));

  assign ps_ce1_n = !ps_sel;
  assign ps_ce2   = 1'b1;
  assign ps_oe_n  = !(ps_sel && strobe && !wr);
  assign ps_we_n  = !(ps_sel && strobe && wr);
  assign ps_lb_n  = !(ps_sel && be[0]);
  assign ps_ub_n  = !(ps_sel && be[BEW-1]);
endmodule

// File: rtl/smc_rdcap.sv
module smc_rdcap
  import smc_pkg::*;
#(
  parameter int DW  = 16,
  parameter int BEW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strobe_last,
  input  logic           wr,
  input  tgt_t           tgt,
  input  logic [BEW-1:0] be,
  input  logic [DW-1:0]  bus_in,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata
);
  // PSRAM returns only enabled bytes; flash returns the full word.
  function automatic logic [DW-1:0] mask_rd(input tgt_t t, input logic [BEW-1:0] b,
                                            input logic [DW-1:0] d);
    logic [DW-1:0] m;
    for (int i = 0; i < BEW; i++)
      m[i*8 +: 8] = (t == TGT_FLASH || b[i]) ? d[i*8 +: 8] : 8'h00;
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= strobe_last && !wr;
      if (strobe_last && !wr) rsp_rdata <= mask_rd(tgt, be, bus_in);
    end
  end
endmodule

// File: rtl/shared_mem_ctrl.sv
module shared_mem_ctrl
  import smc_pkg::*;
#(
  parameter int ADDR_W     = 23,
  parameter int DATA_W     = 16,
  parameter int SHARED_AW  = 21,
  parameter int STROBE_CYC = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_sel,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_in,
  output logic                  fl_rst_n,
  output logic                  fl_ce_n,
  output logic                  fl_oe_n,
  output logic                  fl_we_n,
  output logic                  fl_addr_lat_n,
  output logic                  ps_ce1_n,
  output logic                  ps_ce2,
  output logic                  ps_oe_n,
  output logic                  ps_we_n,
  output logic                  ps_ub_n,
  output logic                  ps_lb_n
);
  localparam int BE_W = DATA_W / 8;

  phase_t            phase;
  tgt_t              tgt;
  logic              wr;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [BE_W-1:0]   be;
  logic              strobe_last;

  always_ff @(posedge clk) begin
    if (!rst_n) fl_rst_n <= 1'b0;
    else        fl_rst_n <= 1'b1;
  end

  smc_seq #(.AW(ADDR_W), .DW(DATA_W), .BEW(BE_W), .STROBE_CYC(STROBE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .phase(phase), .tgt(tgt), .wr(wr), .addr(addr),
    .wdata(wdata), .be(be), .strobe_last(strobe_last)
  );

  smc_pins #(.AW(ADDR_W), .DW(DATA_W), .BEW(BE_W), .SHARED_AW(SHARED_AW)) u_pins (
    .phase(phase), .tgt(tgt), .wr(wr), .addr(addr), .wdata(wdata), .be(be),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_addr_lat_n(fl_addr_lat_n), .ps_ce1_n(ps_ce1_n), .ps_ce2(ps_ce2),
    .ps_oe_n(ps_oe_n), .ps_we_n(ps_we_n), .ps_ub_n(ps_ub_n), .ps_lb_n(ps_lb_n)
  );

  smc_rdcap #(.DW(DATA_W), .BEW(BE_W)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .strobe_last(strobe_last), .wr(wr), .tgt(tgt),
    .be(be), .bus_in(mem_dq_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/shared_mem_ctrl_chk.sv
module shared_mem_ctrl_chk #(
  parameter int ADDR_W     = 23,
  parameter int DATA_W     = 16,
  parameter int SHARED_AW  = 21,
  parameter int STROBE_CYC = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              strobe_last,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe,
  input logic              fl_ce_n,
  input logic              fl_oe_n,
  input logic              fl_we_n,
  input logic              fl_addr_lat_n,
  input logic              ps_ce1_n,
  input logic              ps_oe_n,
  input logic              ps_we_n,
  input logic              ps_ub_n,
  input logic              ps_lb_n
);
  logic        any_low;
  logic [15:0] low_run;

  assign any_low = !fl_oe_n || !fl_we_n || !ps_oe_n || !ps_we_n;

  always_ff @(posedge clk) begin
    if (!rst_n)       low_run <= '0;
    else if (any_low) low_run <= low_run + 16'd1;
    else              low_run <= '0;
  end

  // R2
  excl_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_ce_n && !ps_ce1_n));
  // R2
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_ce_n) || $rose(ps_ce1_n)) |=> (fl_ce_n && ps_ce1_n));
  // R3
  ps_addr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ps_ce1_n |-> (mem_addr[ADDR_W-1:SHARED_AW] == '0));
  // R4
  lat_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_ce_n) |-> !fl_addr_lat_n);
  // R4
  lat_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_oe_n || !fl_we_n) |-> fl_addr_lat_n);
  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_low && low_run != 16'd0) |-> (low_run == 16'(STROBE_CYC)));
  // R6
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_we_n) || $rose(ps_we_n)) |-> (mem_dq_oe && $stable(mem_dq_out)));
  // R6
  dq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_ce_n && ps_ce1_n) |-> !mem_dq_oe);
  // R7
  be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ps_ce1_n |-> (ps_ub_n && ps_lb_n));
  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R8
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(strobe_last));
  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (!fl_ce_n || !ps_ce1_n)));
endmodule

bind shared_mem_ctrl shared_mem_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHARED_AW(SHARED_AW), .STROBE_CYC(STROBE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .strobe_last(strobe_last), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
  .mem_dq_oe(mem_dq_oe), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
  .fl_addr_lat_n(fl_addr_lat_n), .ps_ce1_n(ps_ce1_n), .ps_oe_n(ps_oe_n),
  .ps_we_n(ps_we_n), .ps_ub_n(ps_ub_n), .ps_lb_n(ps_lb_n)
);

// File: tb/tb_shared_mem_ctrl.sv
module tb_shared_mem_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STROBE_N   = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_sel = 1'b0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid, mem_dq_oe, fl_rst_n;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [22:0] mem_addr;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_addr_lat_n;
  logic ps_ce1_n, ps_ce2, ps_oe_n, ps_we_n, ps_ub_n, ps_lb_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_mem_ctrl #(.STROBE_CYC(STROBE_N)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .fl_rst_n(fl_rst_n),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_addr_lat_n(fl_addr_lat_n), .ps_ce1_n(ps_ce1_n), .ps_ce2(ps_ce2),
    .ps_oe_n(ps_oe_n), .ps_we_n(ps_we_n), .ps_ub_n(ps_ub_n), .ps_lb_n(ps_lb_n)
  );

  // Bus-level die models (256 words each) and a separate reference copy.
  logic [15:0] fl_arr [256];
  logic [15:0] ps_arr [256];
  logic [15:0] ref_fl [256];
  logic [15:0] ref_ps [256];
  logic [7:0]  fl_lat = '0;

  function automatic logic [15:0] init_word(input int i, input bit die);
    return 16'(i * 16'h1357) ^ (die ? 16'h3C96 : 16'hA5C3);
  endfunction

  function automatic logic [22:0] exp_addr(input bit sel, input logic [22:0] a);
    return sel ? {2'b00, a[20:0]} : a;
  endfunction

  function automatic logic [15:0] exp_read(input bit sel, input logic [1:0] b,
                                           input logic [15:0] w);
    if (!sel) return w;
    return {(b[1] ? w[15:8] : 8'h00), (b[0] ? w[7:0] : 8'h00)};
  endfunction

  always @(posedge fl_addr_lat_n) fl_lat = mem_addr[7:0];
  always @(posedge fl_we_n) if (rst_n && !fl_ce_n) fl_arr[fl_lat] = mem_dq_out;
  always @(posedge ps_we_n) if (rst_n && !ps_ce1_n) begin
    if (!ps_lb_n) ps_arr[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
    if (!ps_ub_n) ps_arr[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
  end
  always_comb begin
    if (!fl_ce_n && !fl_oe_n)       mem_dq_in = fl_arr[fl_lat];
    else if (!ps_ce1_n && !ps_oe_n) mem_dq_in = ps_arr[mem_addr[7:0]];
    else                            mem_dq_in = 16'hDEAD;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // One access; hold_v keeps the request valid through the busy phases.
  task automatic access(input bit wr, input bit sel, input logic [22:0] a,
                        input logic [15:0] wd, input logic [1:0] b, input bit hold_v);
    logic [15:0] exp_rd;
    int          lows;
    logic        tce, oce, tstb;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_sel = sel; req_addr = a; req_wdata = wd; req_be = b;
    while (!req_ready) @(negedge clk);
    exp_rd = exp_read(sel, b, sel ? ref_ps[a[7:0]] : ref_fl[a[7:0]]);
    @(negedge clk); // setup
    if (!hold_v) req_valid = 0;
    tce = sel ? ps_ce1_n : fl_ce_n;
    oce = sel ? fl_ce_n : ps_ce1_n;
    tstb = sel ? (ps_oe_n & ps_we_n) : (fl_oe_n & fl_we_n);
    chk(!tce && oce, "R2 setup chip enables", {30'd0, tce, oce}, 32'd1);
    chk(tstb, "R5 strobe high in setup", 32'(tstb), 32'd1);
    chk(fl_addr_lat_n == sel, "R4 latch open in flash setup", 32'(fl_addr_lat_n), 32'(sel));
    chk({ps_ub_n, ps_lb_n} == (sel ? ~b : 2'b11), "R7 byte enables",
        32'({ps_ub_n, ps_lb_n}), 32'(sel ? ~b : 2'b11));
    chk(mem_dq_oe == wr, "R6 drive enable in setup", 32'(mem_dq_oe), 32'(wr));
    chk(!req_ready, "R9 ready low in setup", 32'(req_ready), 32'd0);
    lows = 0;
    for (int i = 0; i < STROBE_N; i++) begin
      @(negedge clk);
      if (sel ? (wr ? !ps_we_n : !ps_oe_n) : (wr ? !fl_we_n : !fl_oe_n)) lows++;
      if (i == 0) begin
        chk(mem_addr == exp_addr(sel, a), "R3 address gating", 32'(mem_addr),
            32'(exp_addr(sel, a)));
        chk(fl_addr_lat_n, "R4 latch closed in strobe", 32'(fl_addr_lat_n), 32'd1);
      end
      if (req_ready) chk(0, "R9 ready low in strobe", 32'(req_ready), 32'd0);
    end
    @(negedge clk); // hold
    chk(lows == STROBE_N, "R5 strobe width", 32'(lows), 32'(STROBE_N));
    tce = sel ? ps_ce1_n : fl_ce_n;
    tstb = sel ? (ps_oe_n & ps_we_n) : (fl_oe_n & fl_we_n);
    chk(!tce && tstb, "R5 hold cycle", {30'd0, tce, tstb}, 32'd1);
    chk(rsp_valid == !wr, "R8 response pulse", 32'(rsp_valid), 32'(!wr));
    if (!wr) chk(rsp_rdata == exp_rd, sel ? "R8 R10 psram read" : "R8 R10 flash read",
                 32'(rsp_rdata), 32'(exp_rd));
    if (wr) chk(mem_dq_oe && mem_dq_out == wd, "R6 data held after strobe",
                {15'd0, mem_dq_oe, mem_dq_out}, {15'd0, 1'b1, wd});
    chk(!req_ready, "R9 ready low in hold", 32'(req_ready), 32'd0);
    @(negedge clk); // turnaround
    chk(fl_ce_n && ps_ce1_n && !mem_dq_oe && !rsp_valid && !req_ready,
        "R2 R6 R9 turnaround", {27'd0, fl_ce_n, ps_ce1_n, mem_dq_oe, rsp_valid, req_ready},
        32'h18);
    req_valid = 0;
    if (wr) begin
      if (!sel) ref_fl[a[7:0]] = wd;
      else begin
        if (b[0]) ref_ps[a[7:0]][7:0]  = wd[7:0];
        if (b[1]) ref_ps[a[7:0]][15:8] = wd[15:8];
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      fl_arr[i] = init_word(i, 0); ref_fl[i] = fl_arr[i];
      ps_arr[i] = init_word(i, 1); ref_ps[i] = ps_arr[i];
    end
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!fl_rst_n, "R1 flash reset low in reset", 32'(fl_rst_n), 32'd0);
    chk({fl_ce_n, fl_oe_n, fl_we_n, fl_addr_lat_n, ps_ce1_n, ps_ce2, ps_oe_n, ps_we_n,
         ps_ub_n, ps_lb_n} == 10'h3FF && !mem_dq_oe, "R1 controls idle in reset",
        32'({fl_ce_n, fl_oe_n, fl_we_n, fl_addr_lat_n, ps_ce1_n, ps_ce2, ps_oe_n, ps_we_n,
             ps_ub_n, ps_lb_n, mem_dq_oe}), 32'h7FE);
    rst_n = 1;
    @(negedge clk);
    chk(fl_rst_n && req_ready && ps_ce2 && !mem_dq_oe, "R1 idle after reset",
        {28'd0, fl_rst_n, req_ready, ps_ce2, mem_dq_oe}, 32'hE);

    // Directed corner cases
    access(0, 0, 23'h600012, 16'h0, 2'b11, 0);   // first flash read after reset
    access(1, 0, 23'h600012, 16'hBEEF, 2'b00, 0); // flash write ignores byte enables
    access(0, 0, 23'h000012, 16'h0, 2'b01, 0);
    access(1, 1, 23'h7FFF34, 16'h1234, 2'b01, 1); // psram, top bits must be gated
    access(1, 1, 23'h000034, 16'hAB00, 2'b10, 1);
    access(0, 1, 23'h600034, 16'h0, 2'b11, 1);    // R10 byte-merged readback
    access(1, 1, 23'h000035, 16'hFFFF, 2'b00, 0); // no bytes enabled
    access(0, 1, 23'h000035, 16'h0, 2'b11, 0);
    access(0, 1, 23'h000036, 16'h0, 2'b10, 1);    // upper byte only
    access(0, 0, 23'h200036, 16'h0, 2'b10, 1);    // switch die with valid held

    // Random traffic
    for (int n = 0; n < 300; n++) begin
      logic [22:0] ra;
      ra = 23'($urandom);
      access(1'($urandom), 1'($urandom), {ra[22:4], 4'($urandom_range(0, 15))},
             16'($urandom), 2'($urandom), 1'($urandom));
    end
    @(negedge clk);
    chk(req_ready && fl_ce_n && ps_ce1_n, "R1 idle at end", {29'd0, req_ready, fl_ce_n,
        ps_ce1_n}, 32'h7);
    finish_run();
  end
endmodule